// File: doc/BRIEF.md
# Dual-Mode Host Bus Interface

This block is the host-facing register port of a byte-wide peripheral. A static strap input picks one of two bus protocols. In strobe mode the host uses separate active-low read and write strobes. In direction mode the host frames each access with chip select and gives its direction on a single read/write line. In both modes a 3-bit address selects one of eight byte registers, and data moves over an 8-bit bidirectional bus.

Every control pin passes through a two-stage synchronizer into the internal clock domain. A small state machine (states IDLE, READ, WRITE) then turns pin edges into single-cycle internal read and write strobes. Each strobe comes with a latched address, and a write strobe also carries the latched write byte. A bank of eight byte registers stands in for the peripheral so that the port can be exercised.

The same strap also sets the reset pin polarity and the interrupt pin behaviour. In strobe mode the interrupt is an active-high output that drives only when a control bit enables it. In direction mode the interrupt is an active-low open-drain output.

State transitions:
- IDLE to READ: in strobe mode, a read-strobe fall with chip select low; in direction mode, a chip-select fall with direction high. Either transition emits one read pulse.
- IDLE to WRITE: in strobe mode, a write-strobe fall with chip select low; in direction mode, a chip-select fall with direction low.
- READ to IDLE: in strobe mode, when the read strobe rises or chip select rises; in direction mode, when chip select rises or direction drops.
- WRITE to IDLE (commit): in strobe mode, a write-strobe rise while chip select is still low; in direction mode, a chip-select rise while direction is still low. The commit emits one write pulse.
- WRITE to IDLE (abort): in strobe mode, chip select rises first. No write pulse is emitted.

Top module: `hostbus_front`

## Requirements
- R1: `mode_sel`=1 selects strobe mode and `mode_sel`=0 selects direction mode. A cycle that follows one mode's protocol while the other mode is selected commits no write.
- R2: In strobe mode, a fall of `rd_n` with `cs_n` low causes two things. It emits one `reg_rd` pulse carrying the address. Until `rd_n` rises, it drives the addressed byte onto `bus_data` with `dbus_oe`=1.
- R3: In strobe mode, a fall and then a rise of `wr_n`, with `cs_n` low throughout, emits one `reg_wr` pulse at the rise. The pulse carries the address and data. The byte is stored at that address.
- R4: In direction mode, `wr_n` is the direction (1 = read, 0 = write) and `rd_n` is ignored. A frame with `cs_n` low and direction high drives the addressed byte. A frame with direction low commits its byte when `cs_n` rises.
- R5: With `cs_n` high, strobe activity produces no pulse, stores nothing, and never drives the bus.
- R6: `dbus_oe` is 1 only during a valid read with chip select active; otherwise `bus_data` is high impedance.
- R7: Each accepted strobe edge yields exactly one internal pulse of one clock. `reg_rd` and `reg_wr` are never high together.
- R8: In strobe mode, `irq_pin` follows `irq_req` (active high). `irq_oe` is 1 only when bit 3 of register 4 is 1; otherwise the output is released.
- R9: In direction mode, the interrupt is active-low open drain: `irq_oe`=`irq_req` and `irq_pin`=0.
- R10: Reset is `rst_pin`=1 in strobe mode and `rst_pin`=0 in direction mode. While reset is asserted, `dbus_oe` and `irq_oe` are 0. Reset clears all eight registers to 0.
- R11: The eight registers at addresses 0 to 7 are independent; a write to one leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| mode_sel | input | 1 | Protocol strap: 1 strobe mode, 0 direction mode |
| rst_pin | input | 1 | Reset, polarity set by mode_sel |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe (strobe mode); ignored in direction mode |
| wr_n | input | 1 | Write strobe (strobe mode) or direction, 1 read / 0 write |
| addr | input | 3 | Register address |
| bus_data | inout | 8 | Bidirectional data bus |
| dbus_oe | output | 1 | High while the block drives bus_data |
| irq_req | input | 1 | Interrupt request from the peripheral core |
| irq_pin | output | 1 | Interrupt pin level when driven |
| irq_oe | output | 1 | Interrupt pin drive enable |
| reg_rd | output | 1 | One-cycle internal read strobe |
| reg_wr | output | 1 | One-cycle internal write strobe |
| reg_addr | output | 3 | Latched access address |
| reg_wdata | output | 8 | Latched write byte |

## Verification
The hardest cases to reach are pin sequences that are legal in one mode but mean something else in the other mode. One example is a strobe-style write issued while direction mode is selected, which the block decodes as a read frame. Another is a direction-style write frame issued while strobe mode is selected, which has no write-strobe edge at all. The stimulus runs both protocols in each strap setting and checks that no byte is committed. It also runs a direction-mode write with `rd_n` held low, and strobe activity with chip select released. Random mixes of reads and writes, drawn from a fixed seed, then check every readback against a register model kept by the bench.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } bus_state_e;

    localparam logic MODE_STROBE = 1'b1;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/hb_fsm.sv
module hb_fsm
    import hb_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe_mode,
    input  logic              cs_s,
    input  logic              rd_s,
    input  logic              wr_s,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              rd_pulse,
    output logic              wr_pulse,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] acc_wdata,
    output logic              drive_en
);
    bus_state_e state_q, state_d;
    logic cs_q, rd_q, wr_q;
    logic cs_fall, cs_rise, rd_fall, wr_fall, wr_rise;
    logic start_rd, commit;

    // edge detection on synchronized pins
    assign cs_fall = cs_q & ~cs_s;
    assign cs_rise = ~cs_q & cs_s;
    assign rd_fall = rd_q & ~rd_s;
    assign wr_fall = wr_q & ~wr_s;
    assign wr_rise = ~wr_q & wr_s;

    always_comb begin
        state_d  = state_q;
        start_rd = 1'b0;
        commit   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (strobe_mode == MODE_STROBE) begin
                    if (!cs_s && rd_fall) begin
                        state_d  = ST_READ;
                        start_rd = 1'b1;
                    end else if (!cs_s && wr_fall) begin
                        state_d = ST_WRITE;
                    end
                end else if (cs_fall) begin
                    if (wr_s) begin
                        state_d  = ST_READ;
                        start_rd = 1'b1;
                    end else begin
                        state_d = ST_WRITE;
                    end
                end
            end
            ST_READ: begin
                if (strobe_mode == MODE_STROBE) begin
                    if (rd_s || cs_s) state_d = ST_IDLE;
                end else if (cs_s || !wr_s) begin
                    state_d = ST_IDLE;
                end
            end
            ST_WRITE: begin
                if (strobe_mode == MODE_STROBE) begin
                    if (wr_rise) begin
                        commit  = !cs_s;
                        state_d = ST_IDLE;
                    end else if (cs_s) begin
                        state_d = ST_IDLE;
                    end
                end else if (cs_rise) begin
                    commit  = !wr_s;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            cs_q      <= 1'b1;
            rd_q      <= 1'b1;
            wr_q      <= 1'b1;
            rd_pulse  <= 1'b0;
            wr_pulse  <= 1'b0;
            acc_addr  <= '0;
            acc_wdata <= '0;
        end else begin
            state_q  <= state_d;
            cs_q     <= cs_s;
            rd_q     <= rd_s;
            wr_q     <= wr_s;
            rd_pulse <= start_rd;
            wr_pulse <= commit;
            if (start_rd || commit) acc_addr <= addr_i;
            if (commit) acc_wdata <= wdata_i;
        end
    end

    always_comb begin
        drive_en = (state_q == ST_READ);
    end
endmodule

// File: rtl/hb_regfile.sv
module hb_regfile #(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 8,
    parameter int IRQ_REG = 4,
    parameter int IRQ_BIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_enable
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0][DATA_W-1:0] bank;

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_byte
            logic [DATA_W-1:0] byte_q;
            always_ff @(posedge clk) begin
                if (rst) byte_q <= '0;
                else if (wr_en && wr_addr == ADDR_W'(g)) byte_q <= wr_data;
            end
            assign bank[g] = byte_q;
        end
    endgenerate

    assign rd_data    = bank[rd_addr];
    assign irq_enable = bank[IRQ_REG][IRQ_BIT];
endmodule

// File: rtl/hb_pinctl.sv
module hb_pinctl (
    input  logic strobe_mode,
    input  logic rst_pin,
    input  logic irq_req,
    input  logic irq_enable,
    output logic rst_active,
    output logic irq_pin,
    output logic irq_oe
);
    always_comb begin
        rst_active = strobe_mode ? rst_pin : ~rst_pin;
        irq_pin    = strobe_mode ? irq_req : 1'b0;
        if (rst_active)       irq_oe = 1'b0;
        else if (strobe_mode) irq_oe = irq_enable;
        else                  irq_oe = irq_req;
    end
endmodule

// File: rtl/hostbus_front.sv
module hostbus_front #(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 8,
    parameter int SYNC_N  = 2,
    parameter int IRQ_REG = 4,
    parameter int IRQ_BIT = 3
) (
    input  logic              clk,
    input  logic              mode_sel,
    input  logic              rst_pin,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    inout  wire  [DATA_W-1:0] bus_data,
    output logic              dbus_oe,
    input  logic              irq_req,
    output logic              irq_pin,
    output logic              irq_oe,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata
);
    localparam int CTRL_W = 3;

    logic              rst_active;
    logic [CTRL_W-1:0] ctrl_s;
    logic              drive_en;
    logic              irq_enable;
    logic [DATA_W-1:0] rd_data;

    hb_pinctl u_pins (
        .strobe_mode (mode_sel),
        .rst_pin     (rst_pin),
        .irq_req     (irq_req),
        .irq_enable  (irq_enable),
        .rst_active  (rst_active),
        .irq_pin     (irq_pin),
        .irq_oe      (irq_oe)
    );

    hb_sync #(.WIDTH(CTRL_W), .STAGES(SYNC_N), .RST_VAL('1)) u_sync (
        .clk  (clk),
        .rst  (rst_active),
        .din  ({cs_n, rd_n, wr_n}),
        .dout (ctrl_s)
    );

    hb_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst         (rst_active),
        .strobe_mode (mode_sel),
        .cs_s        (ctrl_s[2]),
        .rd_s        (ctrl_s[1]),
        .wr_s        (ctrl_s[0]),
        .addr_i      (addr),
        .wdata_i     (bus_data),
        .rd_pulse    (reg_rd),
        .wr_pulse    (reg_wr),
        .acc_addr    (reg_addr),
        .acc_wdata   (reg_wdata),
        .drive_en    (drive_en)
    );

    hb_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_REG(IRQ_REG), .IRQ_BIT(IRQ_BIT)) u_regs (
        .clk        (clk),
        .rst        (rst_active),
        .wr_en      (reg_wr),
        .wr_addr    (reg_addr),
        .wr_data    (reg_wdata),
        .rd_addr    (reg_addr),
        .rd_data    (rd_data),
        .irq_enable (irq_enable)
    );

    assign dbus_oe  = drive_en & ~rst_active;
    assign bus_data = dbus_oe ? rd_data : 'z;
endmodule

// File: rtl/hostbus_front_chk.sv
module hostbus_front_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              mode_sel,
    input logic              rst_pin,
    input logic              dbus_oe,
    input logic              irq_pin,
    input logic              irq_oe,
    input logic              reg_rd,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr
);
    logic in_reset;
    assign in_reset = mode_sel ? rst_pin : ~rst_pin;

    AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (in_reset) !(reg_rd && reg_wr)); // R7
    AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (in_reset) reg_wr |=> !reg_wr); // R7
    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (in_reset) reg_rd |=> !reg_rd); // R7
    AST_DRIVE_BEGINS_WITH_READ: assert property (@(posedge clk) disable iff (in_reset) $rose(dbus_oe) |-> reg_rd); // R6
    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (in_reset) reg_wr |-> !dbus_oe); // R6
    AST_READ_ADDR_HELD: assert property (@(posedge clk) disable iff (in_reset) (dbus_oe && $past(dbus_oe)) |-> $stable(reg_addr)); // R2
    AST_RESET_QUIET: assert property (@(posedge clk) in_reset |-> (!dbus_oe && !irq_oe)); // R10
    AST_OPEN_DRAIN_LOW: assert property (@(posedge clk) disable iff (in_reset) (!mode_sel && irq_oe) |-> !irq_pin); // R9
endmodule

bind hostbus_front hostbus_front_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .mode_sel (mode_sel),
    .rst_pin  (rst_pin),
    .dbus_oe  (dbus_oe),
    .irq_pin  (irq_pin),
    .irq_oe   (irq_oe),
    .reg_rd   (reg_rd),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr)
);

// File: tb/sim_hostbus_front.sv
module sim_hostbus_front;
    localparam int AW = 3;
    localparam int DW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          mode_sel, rst_pin, cs_n, rd_n, wr_n, irq_req;
    logic [AW-1:0] addr;
    wire  [DW-1:0] bus_data;
    logic [DW-1:0] tb_d;
    logic          tb_den;
    logic          dbus_oe, irq_pin, irq_oe, reg_rd, reg_wr;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;

    assign bus_data = tb_den ? tb_d : 'z;

    hostbus_front u0 (
        .clk(clk), .mode_sel(mode_sel), .rst_pin(rst_pin), .cs_n(cs_n),
        .rd_n(rd_n), .wr_n(wr_n), .addr(addr), .bus_data(bus_data),
        .dbus_oe(dbus_oe), .irq_req(irq_req), .irq_pin(irq_pin), .irq_oe(irq_oe),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
    );

    int checks = 0;
    int fails = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    bit done = 0;
    logic [AW-1:0] last_wr_addr, last_rd_addr;
    logic [DW-1:0] last_wr_data;
    logic [DW-1:0] model [8];

    always @(posedge clk) begin
        if (reg_wr) begin
            wr_cnt++;
            last_wr_addr <= reg_addr;
            last_wr_data <= reg_wdata;
        end
        if (reg_rd) begin
            rd_cnt++;
            last_rd_addr <= reg_addr;
        end
    end

    function automatic logic [DW-1:0] exp_byte(input logic [AW-1:0] a);
        return model[a];
    endfunction

    function automatic logic exp_irq_oe(input logic m, input logic req, input logic [DW-1:0] ctl);
        return m ? ctl[3] : req;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_model();
        for (int i = 0; i < 8; i++) model[i] = '0;
    endtask

    task automatic do_reset();
        rst_pin = mode_sel ? 1'b1 : 1'b0;
        cyc(3);
        chk("R10", "dbus_oe in reset", dbus_oe, 0);
        chk("R10", "irq_oe in reset", irq_oe, 0);
        rst_pin = ~rst_pin;
        cyc(4);
        clear_model();
    endtask

    task automatic strobe_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        int w0 = wr_cnt;
        int r0 = rd_cnt;
        addr = a; tb_d = d; tb_den = 1'b1; cs_n = 1'b0;
        cyc(2);
        wr_n = 1'b0;
        cyc(5);
        chk("R6", "oe during strobe write", dbus_oe, 0);
        wr_n = 1'b1;
        cyc(6);
        cs_n = 1'b1; tb_den = 1'b0;
        cyc(3);
        chk("R3", "write pulse count", wr_cnt - w0, 1);
        chk("R3", "write addr", last_wr_addr, a);
        chk("R3", "write data", last_wr_data, d);
        chk("R7", "no read pulse on write", rd_cnt - r0, 0);
        model[a] = d;
    endtask

    task automatic strobe_read(input logic [AW-1:0] a);
        int r0 = rd_cnt;
        addr = a; tb_den = 1'b0; cs_n = 1'b0;
        cyc(2);
        rd_n = 1'b0;
        cyc(6);
        chk("R2", "oe during read", dbus_oe, 1);
        chk("R2", "read data", bus_data, exp_byte(a));
        rd_n = 1'b1;
        cyc(6);
        chk("R6", "oe after read", dbus_oe, 0);
        cs_n = 1'b1;
        cyc(3);
        chk("R7", "read pulse count", rd_cnt - r0, 1);
        chk("R2", "read addr", last_rd_addr, a);
    endtask

    task automatic dir_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic rd_low);
        int w0 = wr_cnt;
        int r0 = rd_cnt;
        wr_n = 1'b0; rd_n = rd_low ? 1'b0 : 1'b1;
        addr = a; tb_d = d; tb_den = 1'b1;
        cyc(2);
        cs_n = 1'b0;
        cyc(5);
        chk("R6", "oe during dir write", dbus_oe, 0);
        cs_n = 1'b1;
        cyc(6);
        tb_den = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
        cyc(2);
        chk("R4", "dir write pulse count", wr_cnt - w0, 1);
        chk("R4", "dir write addr", last_wr_addr, a);
        chk("R4", "dir write data", last_wr_data, d);
        chk("R4", "no read pulse in write frame", rd_cnt - r0, 0);
        model[a] = d;
    endtask

    task automatic dir_read(input logic [AW-1:0] a);
        int r0 = rd_cnt;
        wr_n = 1'b1; addr = a; tb_den = 1'b0;
        cyc(2);
        cs_n = 1'b0;
        cyc(6);
        chk("R4", "oe in read frame", dbus_oe, 1);
        chk("R4", "dir read data", bus_data, exp_byte(a));
        cs_n = 1'b1;
        cyc(6);
        chk("R6", "oe after frame", dbus_oe, 0);
        chk("R7", "dir read pulse count", rd_cnt - r0, 1);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int w0;
        int r0;
        void'($urandom(32'd24601));
        mode_sel = 1'b1; rst_pin = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1;
        irq_req = 1'b0; addr = '0; tb_d = '0; tb_den = 1'b0;
        clear_model();
        cyc(1);
        do_reset();

        // strobe mode: reset contents, then each register distinct
        for (int i = 0; i < 8; i++) strobe_read(AW'(i));                 // R10
        for (int i = 0; i < 8; i++) strobe_write(AW'(i), DW'(8'h11 * (i + 1)));
        for (int i = 0; i < 8; i++) strobe_read(AW'(i));                 // R11

        // R5: strobes with chip select released
        w0 = wr_cnt; r0 = rd_cnt;
        addr = 3'd2; tb_d = 8'hFF; tb_den = 1'b1;
        wr_n = 1'b0; cyc(5); wr_n = 1'b1; cyc(5); tb_den = 1'b0;
        rd_n = 1'b0; cyc(5);
        chk("R5", "oe with cs high", dbus_oe, 0);
        rd_n = 1'b1; cyc(4);
        chk("R5", "write pulses with cs high", wr_cnt - w0, 0);
        chk("R5", "read pulses with cs high", rd_cnt - r0, 0);
        strobe_read(3'd2);

        // R1: direction-style write frame while strobe mode is selected
        w0 = wr_cnt;
        wr_n = 1'b0; addr = 3'd5; tb_d = 8'hA5; tb_den = 1'b1; cyc(2);
        cs_n = 1'b0; cyc(5); cs_n = 1'b1; cyc(5);
        wr_n = 1'b1; tb_den = 1'b0; cyc(6);
        chk("R1", "no commit for wrong protocol", wr_cnt - w0, 0);
        strobe_read(3'd5);

        // R8: interrupt output in strobe mode
        strobe_write(3'd4, 8'h08);
        irq_req = 1'b1; cyc(2);
        chk("R8", "irq_oe enabled", irq_oe, exp_irq_oe(1'b1, irq_req, model[4]));
        chk("R8", "irq_pin high", irq_pin, 1);
        irq_req = 1'b0; cyc(2);
        chk("R8", "irq_oe still enabled", irq_oe, 1);
        chk("R8", "irq_pin low", irq_pin, 0);
        strobe_write(3'd4, 8'hF7);
        irq_req = 1'b1; cyc(2);
        chk("R8", "irq_oe disabled", irq_oe, exp_irq_oe(1'b1, irq_req, model[4]));
        irq_req = 1'b0;

        // random mix in strobe mode
        for (int n = 0; n < 60; n++) begin
            logic [AW-1:0] ra = AW'($urandom_range(0, 7));
            if ($urandom_range(0, 1) == 1) strobe_write(ra, DW'($urandom_range(0, 255)));
            else strobe_read(ra);
        end

        // R10: reset clears contents
        do_reset();
        strobe_read(3'd1);
        strobe_read(3'd4);

        // switch to direction mode (reset active low)
        mode_sel = 1'b0; rst_pin = 1'b1;
        do_reset();
        for (int i = 0; i < 8; i++) dir_write(AW'(i), DW'(8'h80 | i), 1'b0);
        for (int i = 0; i < 8; i++) dir_read(AW'(i));                    // R11
        dir_write(3'd6, 8'h3C, 1'b1);                                    // R4 rd_n held low
        dir_read(3'd6);

        // R1: strobe-style write while direction mode is selected
        w0 = wr_cnt;
        addr = 3'd3; tb_d = 8'h5A; tb_den = 1'b1; wr_n = 1'b1; cs_n = 1'b0; cyc(3);
        wr_n = 1'b0; cyc(5); wr_n = 1'b1; cyc(5);
        cs_n = 1'b1; tb_den = 1'b0; cyc(6);
        chk("R1", "no commit for strobe write in dir mode", wr_cnt - w0, 0);
        dir_read(3'd3);

        // R5: direction toggles with chip select released
        w0 = wr_cnt;
        wr_n = 1'b0; cyc(4); wr_n = 1'b1; cyc(4);
        chk("R5", "no pulse in dir mode with cs high", wr_cnt - w0, 0);
        chk("R5", "oe with cs high dir mode", dbus_oe, 0);

        // R9: open-drain interrupt
        irq_req = 1'b1; cyc(2);
        chk("R9", "irq_oe asserted", irq_oe, exp_irq_oe(1'b0, irq_req, model[4]));
        chk("R9", "irq_pin pulls low", irq_pin, 0);
        irq_req = 1'b0; cyc(2);
        chk("R9", "irq released", irq_oe, 0);

        for (int n = 0; n < 60; n++) begin
            logic [AW-1:0] ra = AW'($urandom_range(0, 7));
            if ($urandom_range(0, 1) == 1) dir_write(ra, DW'($urandom_range(0, 255)), 1'b0);
            else dir_read(ra);
        end

        do_reset();
        dir_read(3'd0);
        dir_read(3'd7);

        summary();
        $finish;
    end
endmodule